// File: doc/BRIEF.md
# Fixed-Priority Interrupt Channel Controller

This block gathers a set of level-sensitive interrupt request lines, passes each through a two-flop synchronizer, and gates it with a per-channel enable bit held in a software-writable register. A second register steers every channel to one of two processor interrupt lines. One line is fast and the other is normal. Each line is the registered OR of the enabled, pending channels steered to it. By default the fast line takes precedence: the normal line stays low while any fast request is live.

Software finds the source by reading an index register. There is one index register for each line. It returns one plus the number of the lowest-numbered pending, enabled channel on that line, or zero when none is pending. The value is resolved at the moment of the read, so it reflects the requests live on that cycle. Channel 0 has the highest priority. A handler for channel N can nest safely by clearing enable bits N and above, which leaves only higher-priority channels able to interrupt it. A request that is not cleared at its source stays pending and raises the line again once its enable bit is set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register (offset 0) and the steering register (offset 1) read as zero, both interrupt outputs are low, and both index registers read zero.
- R2: Offset 0 holds the enable bits, where bit n set lets channel n through. Offset 1 holds the steering bits, where bit n set sends channel n to the fast line and clear sends it to the normal line. Both read back what was written.
- R3: A request held high on an enabled channel raises its line on the third rising clock edge after the request is applied: two synchronizer stages plus one output register.
- R4: A channel whose enable bit is clear neither raises a line nor appears in an index. With all enable bits clear, both lines are low one cycle later.
- R5: A read of offset 2 (fast) or offset 3 (normal) returns one plus the lowest-numbered pending, enabled channel steered to that line, or 0 if there is none. Channel 0 has the highest priority and the last channel the lowest.
- R6: The index is resolved from the state present at the read strobe and appears on the read data port after the next rising edge.
- R7: With the default precedence option, the normal line is held low while any fast request is pending and enabled. The normal index register is not affected by this.
- R8: A request held at its source, with its enable bit clear, raises its line one clock after the enable write takes effect.
- R9: Writes to the index offsets have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_CH | Level-sensitive request lines |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Register word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_fast_o | output | 1 | Fast interrupt line |
| irq_norm_o | output | 1 | Normal interrupt line |

## Verification
The assertions assume that the request lines, once synchronized, are steady enough that the encoded index and the pending vector come from the same cycle. They also assume that the bus issues at most one access per cycle, with a known address while the strobe is high. The stimulus changes requests and performs bus accesses only on falling clock edges. Before it samples the lines or reads an index, it holds the requests for at least four cycles, so every check sees settled synchronizer state.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int unsigned OFS_ENABLE = 0;
   localparam int unsigned OFS_STEER  = 1;
   localparam int unsigned OFS_FIDX   = 2;
   localparam int unsigned OFS_NIDX   = 3;

   typedef enum logic [1:0] {
      LINE_NORM = 2'd0,
      LINE_FAST = 2'd1
   } line_e;
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial assert (STAGES >= 2) else $fatal(1, "synchronizer needs two stages or more");

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= d_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
   parameter int unsigned NUM_CH = 32,
   localparam int unsigned IDX_W = $clog2(NUM_CH + 1)
) (
   input  logic [NUM_CH-1:0] vec_i,
   output logic [IDX_W-1:0]  idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i + 1);
      end
   end
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(NUM_CH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  fast_idx_i,
   input  logic [IDX_W-1:0]  norm_idx_i,
   output logic [NUM_CH-1:0] enable_o,
   output logic [NUM_CH-1:0] steer_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [NUM_CH-1:0] enable_q, steer_q;
   logic [DATA_W-1:0] rd_mux;
   logic              wr_en, rd_en;

   assign wr_en = sel_i &  we_i;
   assign rd_en = sel_i & ~we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enable_q <= '0;
         steer_q  <= '0;
      end else if (wr_en) begin
         if (addr_i == ADDR_W'(OFS_ENABLE)) enable_q <= wdata_i[NUM_CH-1:0];
         if (addr_i == ADDR_W'(OFS_STEER))  steer_q  <= wdata_i[NUM_CH-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (addr_i)
         ADDR_W'(OFS_ENABLE): rd_mux[NUM_CH-1:0] = enable_q;
         ADDR_W'(OFS_STEER):  rd_mux[NUM_CH-1:0] = steer_q;
         ADDR_W'(OFS_FIDX):   rd_mux[IDX_W-1:0]  = fast_idx_i;
         ADDR_W'(OFS_NIDX):   rd_mux[IDX_W-1:0]  = norm_idx_i;
         default:             rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rdata_o <= '0;
      else if (rd_en) rdata_o <= rd_mux;
   end

   assign enable_o = enable_q;
   assign steer_o  = steer_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_CH        = 32,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          FAST_PREEMPTS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] req_i,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_fast_o,
   output logic              irq_norm_o
);
   localparam int unsigned IDX_W = $clog2(NUM_CH + 1);

   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= DATA_W) else $fatal(1, "NUM_CH out of range");
      assert (IDX_W <= DATA_W) else $fatal(1, "index does not fit data bus");
      assert ((1 << ADDR_W) > OFS_NIDX) else $fatal(1, "ADDR_W too narrow");
   end

   logic [NUM_CH-1:0] req_s, enable, steer, pending;
   logic [NUM_CH-1:0] vec_line [2];
   logic [IDX_W-1:0]  idx_line [2];
   logic              fast_any, norm_any, fast_q, norm_q;

   prio_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (req_i), .q_o (req_s)
   );

   assign pending           = req_s & enable;
   assign vec_line[LINE_FAST] = pending &  steer;
   assign vec_line[LINE_NORM] = pending & ~steer;

   for (genvar l = 0; l < 2; l++) begin : g_line
      prio_irq_enc #(.NUM_CH(NUM_CH)) u_enc (
         .vec_i (vec_line[l]), .idx_o (idx_line[l])
      );
   end

   prio_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (bus_sel_i),
      .we_i       (bus_we_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .fast_idx_i (idx_line[LINE_FAST]),
      .norm_idx_i (idx_line[LINE_NORM]),
      .enable_o   (enable),
      .steer_o    (steer),
      .rdata_o    (bus_rdata_o)
   );

   assign fast_any = |vec_line[LINE_FAST];

   if (FAST_PREEMPTS) begin : g_preempt
      assign norm_any = (|vec_line[LINE_NORM]) & ~fast_any;
   end else begin : g_indep
      assign norm_any = |vec_line[LINE_NORM];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fast_q <= 1'b0;
         norm_q <= 1'b0;
      end else begin
         fast_q <= fast_any;
         norm_q <= norm_any;
      end
   end

   assign irq_fast_o = fast_q;
   assign irq_norm_o = norm_q;

   // R5: the encoded channel is really pending on its line
   a_r5_fast_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx_line[LINE_FAST] != '0) |-> vec_line[LINE_FAST][idx_line[LINE_FAST] - 1'b1]);
   // R5: no higher-priority channel is skipped
   a_r5_norm_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx_line[LINE_NORM] != '0) |->
      ((vec_line[LINE_NORM] & ~({NUM_CH{1'b1}} << (idx_line[LINE_NORM] - 1'b1))) == '0));
   // R5: empty line encodes zero
   a_r5_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_line[LINE_FAST] == '0) |-> (idx_line[LINE_FAST] == '0));
   // R4: all enables clear silences both lines next cycle
   a_r4_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable == '0) |=> (!irq_fast_o && !irq_norm_o));
   // R3: a line only rises when a steered channel was pending
   a_r3_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_norm_o) |-> $past(vec_line[LINE_NORM] != '0));

   if (FAST_PREEMPTS) begin : g_chk_pre
      // R7: never both lines at once
      a_r7_fast_preempts: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(irq_fast_o && irq_norm_o));
   end
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   localparam int NCH = 32;
   localparam int CLK_PERIOD = 10;

   logic            clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0]  req = '0;
   logic            sel = 1'b0, we = 1'b0;
   logic [2:0]      addr = '0;
   logic [31:0]     wdata = '0, rdata;
   logic            irq_f, irq_n;
   int              checks = 0, errors = 0;
   bit              done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl u0 (
      .clk_i (clk), .rst_ni (rst_n), .req_i (req),
      .bus_sel_i (sel), .bus_we_i (we), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .irq_fast_o (irq_f), .irq_norm_o (irq_n)
   );

   function automatic logic [31:0] exp_idx(logic [31:0] v);
      for (int i = 0; i < NCH; i++) if (v[i]) return 32'(i + 1);
      return 32'd0;
   endfunction

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic bus_wr(int a, logic [31:0] d);
      @(negedge clk); sel = 1; we = 1; addr = 3'(a); wdata = d;
      @(negedge clk); sel = 0; we = 0;
   endtask

   task automatic bus_rd(int a, output logic [31:0] d);
      @(negedge clk); sel = 1; we = 0; addr = 3'(a);
      @(negedge clk); sel = 0; d = rdata;
   endtask

   task automatic settle(); repeat (4) @(negedge clk); endtask

   task automatic check_all(string rq, logic [31:0] r, logic [31:0] m, logic [31:0] s);
      logic [31:0] fv, nv, d;
      fv = r & m & s; nv = r & m & ~s;
      chk({rq, " fast line"}, 32'(irq_f), 32'(fv != 0));
      chk({rq, " normal line"}, 32'(irq_n), 32'((nv != 0) && (fv == 0)));
      bus_rd(2, d); chk({rq, " fast index"}, d, exp_idx(fv));
      bus_rd(3, d); chk({rq, " normal index"}, d, exp_idx(nv));
   endtask

   initial begin
      int unsigned seed_v;
      logic [31:0] d, m, s, r;
      seed_v = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 fast out", 32'(irq_f), 0); chk("R1 norm out", 32'(irq_n), 0);
      bus_rd(0, d); chk("R1 enable", d, 0);
      bus_rd(1, d); chk("R1 steer", d, 0);
      bus_rd(2, d); chk("R1 fidx", d, 0);
      bus_rd(3, d); chk("R1 nidx", d, 0);
      // R2 readback
      bus_wr(0, 32'hA5A5_0F0F); bus_rd(0, d); chk("R2 enable rb", d, 32'hA5A5_0F0F);
      bus_wr(1, 32'h0000_00F0); bus_rd(1, d); chk("R2 steer rb", d, 32'h0000_00F0);
      // R3 latency: normal channel 9
      bus_wr(1, 0); bus_wr(0, 32'hFFFF_FFFF);
      @(negedge clk); req = 32'h200;
      @(negedge clk); chk("R3 edge1", 32'(irq_n), 0);
      @(negedge clk); chk("R3 edge2", 32'(irq_n), 0);
      @(negedge clk); chk("R3 edge3", 32'(irq_n), 1);
      // R5 priority extremes and nesting
      req = 32'h8000_0224; settle(); check_all("R5 prio", req, 32'hFFFF_FFFF, 0);
      bus_wr(0, 32'h0000_0003); @(negedge clk);
      check_all("R4 nest mask", req, 32'h3, 0);
      req = 32'h8000_0226; settle(); check_all("R4 nest ch1", req, 32'h3, 0);
      // R7 preemption, R6 index of normal kept
      bus_wr(0, 32'hFFFF_FFFF); bus_wr(1, 32'h8); req = 32'h18; settle();
      chk("R7 fast high", 32'(irq_f), 1); chk("R7 norm held", 32'(irq_n), 0);
      bus_rd(3, d); chk("R7 nidx kept", d, 5);
      bus_rd(2, d); chk("R6 fidx", d, 4);
      // R8 held request re-raises
      bus_wr(1, 0); bus_wr(0, 0); req = 32'h80; settle();
      chk("R8 masked low", 32'(irq_n), 0);
      bus_wr(0, 32'h80);
      chk("R8 not yet", 32'(irq_n), 0);
      @(negedge clk); chk("R8 raised", 32'(irq_n), 1);
      // R9 writes to index ignored
      bus_wr(2, 32'h1F); bus_wr(3, 32'h3);
      bus_rd(3, d); chk("R9 nidx", d, 8);
      bus_rd(2, d); chk("R9 fidx", d, 0);
      bus_rd(0, d); chk("R9 enable", d, 32'h80);
      chk("R9 line", 32'(irq_n), 1);
      // random mix (R4 R5 R7)
      for (int it = 0; it < 200; it++) begin
         m = $urandom(); s = $urandom(); r = $urandom() & $urandom();
         if (it % 7 == 0) r = 32'h8000_0000;
         bus_wr(0, m); bus_wr(1, s); req = r; settle();
         check_all("R5 random", r, m, s);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule